// File: doc/BRIEF.md
# DMA Channel Address and Word-Count Register Set

This block holds the four 16-bit registers of one DMA channel: a base and a current address, and a base and a current word count. A host programs them over an 8-bit bus, one byte at a time. An internal byte pointer steers each access to the low byte first and then to the high byte. Each host write updates the base register and its current copy together. A host read always returns the current copy, so the base values cannot be read back.

During a service the channel controller pulses a transfer-done input once per transfer. On each pulse the current address steps up or down by one, or stays put when the hold flag is set. The current word count steps down by one. The terminal-count output pulses when the count passes from zero to all ones, so a programmed value N yields N+1 transfers. An end-of-process input with autoinitialize enabled copies both base registers back into the current registers. The current address is always visible on an output port for the address path.

Top module: `dma_chan_regs`

## Requirements
- R1: Reset clears all four registers, sets the byte pointer to the low byte, and drives tc low, so cur_addr reads 0000h and host reads return 00h.
- R2: Each accepted host access (read or write) uses the byte selected by the pointer (0 selects bits 7:0, 1 selects bits 15:8) and then toggles the pointer. A ptr_clr pulse returns the pointer to the low byte. When ptr_clr and an access arrive in the same cycle, the access uses the old pointer and the pointer ends on the low byte.
- R3: An accepted host write loads the addressed byte of both the base and the current register chosen by reg_sel (0 selects the address pair, 1 selects the word-count pair).
- R4: While host_rd is accepted, rd_data shows the addressed byte of the current register chosen by reg_sel. At all other times rd_data is 00h. Base registers are never visible.
- R5: Host reads and writes are ignored while hold_ack is 1. They change no register and do not toggle the pointer.
- R6: A transfer-done pulse is accepted only while hold_ack is 1. It adds one to the current address when dec_mode is 0 and subtracts one when dec_mode is 1, wrapping modulo 2^16.
- R7: While addr_hold is 1, accepted transfers leave the current address unchanged but still decrement the word count.
- R8: Each accepted transfer decrements the current word count. tc is high for exactly the one cycle after the transfer that takes the count from 0000h to FFFFh, so a programmed count N gives tc on transfer N+1.
- R9: eop_in with auto_init set copies both base registers into the current registers. This reload takes precedence over a transfer-done pulse in the same cycle, which is then dropped and gives no tc.
- R10: eop_in without auto_init has no effect, so after tc the count stays at FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| reg_sel | input | 1 | 0 = address pair, 1 = word-count pair |
| ptr_clr | input | 1 | Return the byte pointer to the low byte |
| wr_data | input | 8 | Host write byte |
| hold_ack | input | 1 | Bus granted to DMA; blocks host access |
| xfer_done | input | 1 | One pulse per completed transfer |
| dec_mode | input | 1 | 1 = address counts down |
| addr_hold | input | 1 | Freeze current address |
| auto_init | input | 1 | Enable reload on end-of-process |
| eop_in | input | 1 | End-of-process |
| rd_data | output | 8 | Host read byte |
| cur_addr | output | 16 | Current address |
| tc | output | 1 | Terminal-count pulse |

## Verification
Some properties are checked on every cycle: the pointer toggles and clears, the low and high bytes match after a write, the address steps by one or freezes, the count steps down, tc appears exactly when a transfer leaves zero, and the address stays put under a blocked write or a plain end-of-process. Other behaviours need the bench's scenarios. These are the N+1 transfer count observed end to end, readback of both bytes through the pointer, and the proof that the base values survive transfers and come back on an autoinitialize. The bench also shows that a reload drops a transfer in the same cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
   typedef enum logic {
      SEL_ADDR  = 1'b0,
      SEL_COUNT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   output logic ptr_hi
);
   always_ff @(posedge clk) begin
      if (!rst_n)    ptr_hi <= 1'b0;
      else if (clr)  ptr_hi <= 1'b0;
      else if (step) ptr_hi <= ~ptr_hi;
   end

   // R2: each access flips the pointer, clear forces low
   a_r2_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr) |=> (ptr_hi != $past(ptr_hi)));
   a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !ptr_hi);
endmodule

// File: rtl/dma_reg_pair.sv
module dma_reg_pair #(
   parameter int REG_W    = 16,
   parameter int BUS_W    = 8,
   parameter bit IS_COUNT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_lo,
   input  logic             wr_hi,
   input  logic [BUS_W-1:0] wr_byte,
   input  logic             reload,
   input  logic             step,
   input  logic             dec,
   input  logic             freeze,
   output logic [REG_W-1:0] cur
);
   localparam logic [REG_W-1:0] ONE = REG_W'(1);

   logic [REG_W-1:0] base;
   logic [REG_W-1:0] stepped;

   generate
      if (IS_COUNT) begin : g_count
         assign stepped = cur - ONE;
         // R8: the count drops by one per transfer
         a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !reload && !wr_lo && !wr_hi) |=> (cur == $past(cur) - ONE));
      end else begin : g_addr
         assign stepped = freeze ? cur : (dec ? cur - ONE : cur + ONE);
         // R6: the address moves by one in the chosen direction
         a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
            (step && !freeze && !reload && !wr_lo && !wr_hi) |=>
               (cur == ($past(dec) ? $past(cur) - ONE : $past(cur) + ONE)));
         // R7: hold keeps the address still
         a_r7_addr_freeze: assert property (@(posedge clk) disable iff (!rst_n)
            (step && freeze && !reload && !wr_lo && !wr_hi) |=> $stable(cur));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base <= '0;
         cur  <= '0;
      end else if (wr_lo || wr_hi) begin
         if (wr_lo) begin
            base[BUS_W-1:0] <= wr_byte;
            cur[BUS_W-1:0]  <= wr_byte;
         end
         if (wr_hi) begin
            base[REG_W-1:BUS_W] <= wr_byte;
            cur[REG_W-1:BUS_W]  <= wr_byte;
         end
      end else if (reload) begin
         cur <= base;
      end else if (step) begin
         cur <= stepped;
      end
   end

   // R3: a written byte lands in base and current alike
   a_r3_lo_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (cur[BUS_W-1:0] == base[BUS_W-1:0]));
   a_r3_hi_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (cur[REG_W-1:BUS_W] == base[REG_W-1:BUS_W]));
   // R9: reload restores the stored base
   a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (reload && !wr_lo && !wr_hi) |=> (cur == $past(base)));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
   parameter int REG_W = 16,
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_wr,
   input  logic             host_rd,
   input  logic             reg_sel,
   input  logic             ptr_clr,
   input  logic [BUS_W-1:0] wr_data,
   input  logic             hold_ack,
   input  logic             xfer_done,
   input  logic             dec_mode,
   input  logic             addr_hold,
   input  logic             auto_init,
   input  logic             eop_in,
   output logic [BUS_W-1:0] rd_data,
   output logic [REG_W-1:0] cur_addr,
   output logic             tc
);
   import dma_chan_pkg::*;

   localparam int LANES = REG_W / BUS_W;

   generate
      if (LANES != 2 || REG_W % BUS_W != 0) begin : g_bad_width
         $error("dma_chan_regs: REG_W must be exactly twice BUS_W");
      end
   endgenerate

   reg_sel_e         sel;
   logic             ptr_hi;
   logic             acc, wr_acc, rd_acc;
   logic             reload, xfer_acc;
   logic             wr_addr_lo, wr_addr_hi, wr_cnt_lo, wr_cnt_hi;
   logic [REG_W-1:0] cur_cnt;
   logic [REG_W-1:0] rd_word;
   logic             tc_q;

   assign sel      = reg_sel_e'(reg_sel);
   assign wr_acc   = host_wr && !hold_ack;
   assign rd_acc   = host_rd && !hold_ack;
   assign acc      = wr_acc || rd_acc;
   assign reload   = eop_in && auto_init;
   assign xfer_acc = xfer_done && hold_ack && !reload;

   assign wr_addr_lo = wr_acc && (sel == SEL_ADDR)  && !ptr_hi;
   assign wr_addr_hi = wr_acc && (sel == SEL_ADDR)  &&  ptr_hi;
   assign wr_cnt_lo  = wr_acc && (sel == SEL_COUNT) && !ptr_hi;
   assign wr_cnt_hi  = wr_acc && (sel == SEL_COUNT) &&  ptr_hi;

   dma_byte_ptr i_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (ptr_clr),
      .step   (acc),
      .ptr_hi (ptr_hi)
   );

   dma_reg_pair #(.REG_W(REG_W), .BUS_W(BUS_W), .IS_COUNT(1'b0)) i_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_addr_lo),
      .wr_hi   (wr_addr_hi),
      .wr_byte (wr_data),
      .reload  (reload),
      .step    (xfer_acc),
      .dec     (dec_mode),
      .freeze  (addr_hold),
      .cur     (cur_addr)
   );

   dma_reg_pair #(.REG_W(REG_W), .BUS_W(BUS_W), .IS_COUNT(1'b1)) i_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lo   (wr_cnt_lo),
      .wr_hi   (wr_cnt_hi),
      .wr_byte (wr_data),
      .reload  (reload),
      .step    (xfer_acc),
      .dec     (1'b1),
      .freeze  (1'b0),
      .cur     (cur_cnt)
   );

   always_comb begin
      rd_word = (sel == SEL_COUNT) ? cur_cnt : cur_addr;
      rd_data = '0;
      if (rd_acc) rd_data = ptr_hi ? rd_word[REG_W-1:BUS_W] : rd_word[BUS_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) tc_q <= 1'b0;
      else        tc_q <= xfer_acc && (cur_cnt == '0);
   end
   assign tc = tc_q;

   // R8: tc follows exactly the transfer that leaves zero
   a_r8_tc_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_acc && cur_cnt == '0) |=> (tc && cur_cnt == '1));
   a_r8_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tc |-> ($past(xfer_acc) && $past(cur_cnt) == '0));
   // R5: host strobes under hold_ack leave the address alone
   a_r5_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && hold_ack && !xfer_done && !eop_in) |=> $stable(cur_addr));
   // R10: end-of-process without autoinit changes nothing
   a_r10_plain_eop: assert property (@(posedge clk) disable iff (!rst_n)
      (eop_in && !auto_init && !xfer_acc && !wr_acc) |=> ($stable(cur_addr) && $stable(cur_cnt)));
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 0, host_rd = 0, reg_sel = 0, ptr_clr = 0;
   logic [7:0]  wr_data = 0;
   logic        hold_ack = 0, xfer_done = 0, dec_mode = 0, addr_hold = 0;
   logic        auto_init = 0, eop_in = 0;
   logic [7:0]  rd_data;
   logic [15:0] cur_addr;
   logic        tc;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dma_chan_regs i_dma_chan_regs (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .reg_sel(reg_sel), .ptr_clr(ptr_clr), .wr_data(wr_data),
      .hold_ack(hold_ack), .xfer_done(xfer_done), .dec_mode(dec_mode),
      .addr_hold(addr_hold), .auto_init(auto_init), .eop_in(eop_in),
      .rd_data(rd_data), .cur_addr(cur_addr), .tc(tc)
   );

   localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_XF = 3'd2, OP_EOP = 3'd3;

   typedef struct packed {
      logic [2:0]  op;
      logic        flg;
      logic        sel;
      logic [7:0]  data;
      logic [15:0] exp;
      logic        etc;
      logic [3:0]  req;
   } vec_t;

   // flg: dec_mode for OP_XF, auto_init for OP_EOP
   localparam vec_t VEC [14] = '{
      '{OP_WR,  1'b0, 1'b0, 8'h34, 16'h0000, 1'b0, 4'd3},  // R3 address low
      '{OP_WR,  1'b0, 1'b0, 8'h12, 16'h0000, 1'b0, 4'd3},  // R3 address high
      '{OP_WR,  1'b0, 1'b1, 8'h01, 16'h0000, 1'b0, 4'd3},  // R3 count low
      '{OP_WR,  1'b0, 1'b1, 8'h00, 16'h0000, 1'b0, 4'd3},  // R3 count high
      '{OP_RD,  1'b0, 1'b0, 8'h00, 16'h0034, 1'b0, 4'd4},  // R4 low byte first
      '{OP_RD,  1'b0, 1'b0, 8'h00, 16'h0012, 1'b0, 4'd4},  // R4 high byte
      '{OP_XF,  1'b0, 1'b0, 8'h00, 16'h1235, 1'b0, 4'd6},  // R6 increment
      '{OP_XF,  1'b1, 1'b0, 8'h00, 16'h1234, 1'b1, 4'd8},  // R8 second transfer wraps
      '{OP_RD,  1'b0, 1'b1, 8'h00, 16'h00FF, 1'b0, 4'd8},  // R8 count now FFFF
      '{OP_RD,  1'b0, 1'b1, 8'h00, 16'h00FF, 1'b0, 4'd8},
      '{OP_XF,  1'b0, 1'b0, 8'h00, 16'h1235, 1'b0, 4'd6},
      '{OP_EOP, 1'b1, 1'b0, 8'h00, 16'h1234, 1'b0, 4'd9},  // R9 reload address
      '{OP_RD,  1'b0, 1'b1, 8'h00, 16'h0001, 1'b0, 4'd9},  // R9 reload count
      '{OP_RD,  1'b0, 1'b1, 8'h00, 16'h0000, 1'b0, 4'd9}
   };

   task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle();
      host_wr = 0; host_rd = 0; ptr_clr = 0; xfer_done = 0; eop_in = 0;
      auto_init = 0; addr_hold = 0; dec_mode = 0; hold_ack = 0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic hwrite(input logic sel, input logic [7:0] d);
      reg_sel = sel; wr_data = d; host_wr = 1; tick();
   endtask

   task automatic hread(input logic sel, output logic [7:0] d);
      reg_sel = sel; host_rd = 1; #1; d = rd_data; tick();
   endtask

   task automatic xfer(input logic dec, input logic hold);
      hold_ack = 1; xfer_done = 1; dec_mode = dec; addr_hold = hold; tick();
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      string rq;
      idle();
      @(negedge clk); @(negedge clk);
      check(cur_addr == 16'h0 && tc == 1'b0, "R1 reset addr/tc", cur_addr, 16'h0);
      rst_n = 1; @(negedge clk);
      hread(1'b1, b);
      check(b == 8'h00, "R1 reset count byte", {8'h0, b}, 16'h0);
      hread(1'b1, b);  // pointer back to low

      for (int i = 0; i < 14; i++) begin
         rq = $sformatf("R%0d vec %0d", VEC[i].req, i);
         case (VEC[i].op)
            OP_WR: hwrite(VEC[i].sel, VEC[i].data);
            OP_RD: begin
               hread(VEC[i].sel, b);
               check(b == VEC[i].exp[7:0], rq, {8'h0, b}, VEC[i].exp);
            end
            OP_XF: begin
               xfer(VEC[i].flg, 1'b0);
               check(cur_addr == VEC[i].exp && tc == VEC[i].etc, rq, {cur_addr[14:0], tc}, {VEC[i].exp[14:0], VEC[i].etc});
            end
            default: begin
               hold_ack = 1; eop_in = 1; auto_init = VEC[i].flg; tick();
               check(cur_addr == VEC[i].exp && tc == 1'b0, rq, cur_addr, VEC[i].exp);
            end
         endcase
      end

      // R8: tc lasts a single cycle
      xfer(1'b0, 1'b0);
      tick();
      check(tc == 1'b0, "R8 tc one cycle", {15'h0, tc}, 16'h0);

      // R6: wrap both ways; transfers ignored without hold_ack
      hwrite(1'b0, 8'hFF); hwrite(1'b0, 8'hFF);
      xfer(1'b0, 1'b0);
      check(cur_addr == 16'h0000, "R6 up wrap", cur_addr, 16'h0000);
      xfer(1'b1, 1'b0);
      check(cur_addr == 16'hFFFF, "R6 down wrap", cur_addr, 16'hFFFF);
      xfer_done = 1; tick();
      check(cur_addr == 16'hFFFF, "R6 transfer without hold_ack", cur_addr, 16'hFFFF);

      // R7: hold freezes address, count still moves
      hwrite(1'b1, 8'h05); hwrite(1'b1, 8'h00);
      xfer(1'b0, 1'b1);
      check(cur_addr == 16'hFFFF, "R7 address held", cur_addr, 16'hFFFF);
      hread(1'b1, b); check(b == 8'h04, "R7 count moved", {8'h0, b}, 16'h0004);
      hread(1'b1, b);

      // R5: host strobes under hold_ack ignored, pointer untouched
      hold_ack = 1; host_wr = 1; reg_sel = 0; wr_data = 8'hAA; tick();
      hold_ack = 1; host_rd = 1; reg_sel = 0; #1;
      check(rd_data == 8'h00, "R5 blocked read", {8'h0, rd_data}, 16'h0);
      tick();
      check(cur_addr == 16'hFFFF, "R5 blocked write", cur_addr, 16'hFFFF);
      hwrite(1'b0, 8'h55);
      check(cur_addr == 16'hFF55, "R5 pointer unchanged", cur_addr, 16'hFF55);

      // R2: clear returns pointer to low byte; clear with access
      ptr_clr = 1; tick();
      hwrite(1'b0, 8'h66);
      check(cur_addr == 16'hFF66, "R2 clear then low byte", cur_addr, 16'hFF66);
      ptr_clr = 1; reg_sel = 0; wr_data = 8'h77; host_wr = 1; tick();
      check(cur_addr == 16'h77_66, "R2 access uses old pointer", cur_addr, 16'h7766);
      hwrite(1'b0, 8'h11);
      check(cur_addr == 16'h7711, "R2 pointer cleared after", cur_addr, 16'h7711);
      hwrite(1'b0, 8'h01);  // pointer back to low, addr 0111

      // R10: tc then plain eop keeps FFFF
      hwrite(1'b1, 8'h00); hwrite(1'b1, 8'h00);
      xfer(1'b0, 1'b0);
      check(tc == 1'b1, "R8 count zero gives tc at once", {15'h0, tc}, 16'h1);
      hold_ack = 1; eop_in = 1; tick();
      hread(1'b1, b); check(b == 8'hFF, "R10 count low stays", {8'h0, b}, 16'h00FF);
      hread(1'b1, b); check(b == 8'hFF, "R10 count high stays", {8'h0, b}, 16'h00FF);
      check(cur_addr == 16'h0112, "R10 address unchanged", cur_addr, 16'h0112);

      // R9: reload wins over a same-cycle transfer, no tc
      hold_ack = 1; eop_in = 1; auto_init = 1; xfer_done = 1; tick();
      check(cur_addr == 16'h0111 && tc == 1'b0, "R9 reload priority", cur_addr, 16'h0111);
      hread(1'b1, b); check(b == 8'h00, "R9 count restored", {8'h0, b}, 16'h0);
      hread(1'b1, b);

      // R1: reset mid run
      rst_n = 0; tick(); rst_n = 1;
      check(cur_addr == 16'h0 && tc == 1'b0, "R1 reset mid run", cur_addr, 16'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule